// File: doc/BRIEF.md
# Iterative Shift-Subtract Integer Divider

This block divides one integer by another over several clock cycles. It keeps area small by using one subtractor again and again. A partial remainder and a working quotient sit side by side in two registers. On each clock the pair shifts left by one bit and the subtractor tries to take the divisor away from the partial remainder. The sign of the difference gives one quotient bit. After WIDTH such steps the quotient and remainder are ready.

A caller presents two operands and pulses `start_i`. The block raises `busy_o` while it works and then pulses `done_o` for one cycle. At that point it also loads `quot_o` and `rem_o`. The `signed_i` input is sampled together with the operands and selects two's-complement operation. In signed mode the block first reduces both operands to magnitudes and runs the unsigned steps. It then spends one more cycle restoring the signs. The result is truncating division: the quotient rounds toward zero. A zero divisor is not trapped, and the block returns a well-defined pattern instead.

Top module: `seq_divider`

## Requirements
- R1: In unsigned mode (`signed_i`=0 when started), the block delivers `quot_o` = floor(dividend/divisor) and `rem_o` = dividend mod divisor, both WIDTH bits, for any nonzero divisor.
- R2: In unsigned mode, `done_o` is high in the cycle after the WIDTH+1-th rising edge that follows the edge sampling the accepted start.
- R3: In signed mode (`signed_i`=1 when started), operands are two's complement. The quotient magnitude is |a|/|b|, negated when exactly one operand is negative, and taken modulo 2^WIDTH. The remainder magnitude is |a| mod |b| with the dividend's sign. `done_o` follows one edge later than in R2, after WIDTH+2 edges.
- R4: With a zero divisor, the unsigned result is a quotient of all ones and a remainder equal to the dividend. In signed mode the sign rules of R3 are applied to a quotient magnitude of all ones and a remainder magnitude of |dividend|. `done_o` still arrives on the normal schedule.
- R5: `done_o` lasts exactly one cycle. `busy_o` is high from the cycle after an accepted start until `done_o` rises, and it is low whenever `done_o` is high.
- R6: A start is accepted only while `busy_o` is low. A `start_i` pulse during `busy_o` has no effect on the running result or its timing, and neither do changes to the operand or mode inputs.
- R7: `quot_o` and `rem_o` change only in a cycle where `done_o` is high. They hold their values until the next completion.
- R8: While `rst_ni` is low, `busy_o`, `done_o`, `quot_o` and `rem_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a division; accepted when not busy |
| signed_i | input | 1 | 1 selects two's-complement operands, sampled with start |
| dividend_i | input | WIDTH | Dividend, sampled with start |
| divisor_i | input | WIDTH | Divisor, sampled with start |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quot_o | output | WIDTH | Quotient, valid from done |
| rem_o | output | WIDTH | Remainder, valid from done |

## Verification
The checker's arithmetic and latency properties depend on values it captures when a start is accepted. They therefore assume that `start_i` and the operands are stable around the clock edge and are never X. The bench drives every input on the falling edge to honour this. The properties also assume that only one operation is in flight. The bench issues its disruptive start only while `busy_o` is high, so R6 is exercised without breaking that assumption. Signed extremes, such as the most negative dividend over minus one and a zero divisor with a negative dividend, come from directed cases. A randomized sweep covers both modes on top of these.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FIX,
    ST_OUT
  } div_state_e;
endpackage

// File: rtl/div_sign_prep.sv
module div_sign_prep #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] dividend_i,
  input  logic [WIDTH-1:0] divisor_i,
  input  logic             signed_i,
  output logic [WIDTH-1:0] mag_dvd_o,
  output logic [WIDTH-1:0] mag_dvs_o,
  output logic             neg_quot_o,
  output logic             neg_rem_o
);
  logic dvd_neg, dvs_neg;

  assign dvd_neg    = signed_i & dividend_i[WIDTH-1];
  assign dvs_neg    = signed_i & divisor_i[WIDTH-1];
  assign mag_dvd_o  = dvd_neg ? (~dividend_i + 1'b1) : dividend_i;
  assign mag_dvs_o  = dvs_neg ? (~divisor_i + 1'b1) : divisor_i;
  assign neg_quot_o = dvd_neg ^ dvs_neg;
  assign neg_rem_o  = dvd_neg;
endmodule

// File: rtl/div_step.sv
module div_step #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] part_i,
  input  logic [WIDTH-1:0] work_i,
  input  logic [WIDTH-1:0] dvs_i,
  output logic [WIDTH-1:0] part_o,
  output logic [WIDTH-1:0] work_o
);
  localparam int XW = WIDTH + 1;

  logic [XW-1:0] shifted;
  logic [XW-1:0] diff;
  logic          fits;

  // part < dvs holds between steps, so diff lies in (-2^W, 2^W) and its MSB is a true sign
  assign shifted = {part_i, work_i[WIDTH-1]};
  assign diff    = shifted - {1'b0, dvs_i};
  assign fits    = ~diff[XW-1];
  assign part_o  = fits ? diff[WIDTH-1:0] : shifted[WIDTH-1:0];
  assign work_o  = {work_i[WIDTH-2:0], fits};
endmodule

// File: rtl/div_sign_fix.sv
module div_sign_fix #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] quot_i,
  input  logic [WIDTH-1:0] rem_i,
  input  logic             neg_quot_i,
  input  logic             neg_rem_i,
  output logic [WIDTH-1:0] quot_o,
  output logic [WIDTH-1:0] rem_o
);
  assign quot_o = neg_quot_i ? (~quot_i + 1'b1) : quot_i;
  assign rem_o  = neg_rem_i  ? (~rem_i + 1'b1)  : rem_i;
endmodule

// File: rtl/seq_divider.sv
module seq_divider
  import div_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             signed_i,
  input  logic [WIDTH-1:0] dividend_i,
  input  logic [WIDTH-1:0] divisor_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] quot_o,
  output logic [WIDTH-1:0] rem_o
);
  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  div_state_e       state_q;
  logic [WIDTH-1:0] part_q, work_q, dvs_q;
  logic [CW-1:0]    cnt_q;
  logic             sgn_q, negq_q, negr_q;

  logic [WIDTH-1:0] mag_dvd, mag_dvs, part_nxt, work_nxt, quot_fix, rem_fix;
  logic             neg_quot, neg_rem;

  div_sign_prep #(.WIDTH(WIDTH)) u_prep (
    .dividend_i (dividend_i),
    .divisor_i  (divisor_i),
    .signed_i   (signed_i),
    .mag_dvd_o  (mag_dvd),
    .mag_dvs_o  (mag_dvs),
    .neg_quot_o (neg_quot),
    .neg_rem_o  (neg_rem)
  );

  div_step #(.WIDTH(WIDTH)) u_step (
    .part_i (part_q),
    .work_i (work_q),
    .dvs_i  (dvs_q),
    .part_o (part_nxt),
    .work_o (work_nxt)
  );

  div_sign_fix #(.WIDTH(WIDTH)) u_fix (
    .quot_i     (work_q),
    .rem_i      (part_q),
    .neg_quot_i (negq_q),
    .neg_rem_i  (negr_q),
    .quot_o     (quot_fix),
    .rem_o      (rem_fix)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      part_q  <= '0;
      work_q  <= '0;
      dvs_q   <= '0;
      cnt_q   <= '0;
      sgn_q   <= 1'b0;
      negq_q  <= 1'b0;
      negr_q  <= 1'b0;
      quot_o  <= '0;
      rem_o   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            part_q  <= '0;
            work_q  <= mag_dvd;
            dvs_q   <= mag_dvs;
            sgn_q   <= signed_i;
            negq_q  <= neg_quot;
            negr_q  <= neg_rem;
            cnt_q   <= '0;
            state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          part_q <= part_nxt;
          work_q <= work_nxt;
          cnt_q  <= cnt_q + 1'b1;
          if (cnt_q == LAST) state_q <= sgn_q ? ST_FIX : ST_OUT;
        end
        ST_FIX: begin
          part_q  <= rem_fix;
          work_q  <= quot_fix;
          state_q <= ST_OUT;
        end
        ST_OUT: begin
          quot_o  <= work_q;
          rem_o   <= part_q;
          done_o  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/div_checker.sv
module div_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             signed_i,
  input logic [WIDTH-1:0] dividend_i,
  input logic [WIDTH-1:0] divisor_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [WIDTH-1:0] quot_o,
  input logic [WIDTH-1:0] rem_o
);
  localparam logic [15:0] LAT_U = 16'(WIDTH + 2);
  localparam logic [15:0] LAT_S = 16'(WIDTH + 3);

  logic [15:0]      lat_cnt;
  logic             sgn_l;
  logic [WIDTH-1:0] dvd_l, dvs_l;
  logic             accept;

  assign accept = start_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_cnt <= '0;
      sgn_l   <= 1'b0;
      dvd_l   <= '0;
      dvs_l   <= '0;
    end else if (accept) begin
      lat_cnt <= 16'd1;
      sgn_l   <= signed_i;
      dvd_l   <= dividend_i;
      dvs_l   <= divisor_i;
    end else if (busy_o) begin
      lat_cnt <= lat_cnt + 16'd1;
    end
  end

  a_r5_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r5_busy_done_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

  a_r6_accept_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> busy_o);

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(quot_o) && $stable(rem_o)));

  // R2 and R3 latency, counted in busy cycles plus the accepting edge
  a_r2_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !sgn_l) |-> (lat_cnt == LAT_U));

  a_r3_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && sgn_l) |-> (lat_cnt == LAT_S));

  a_r1_unsigned_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !sgn_l && dvs_l != '0) |-> (quot_o == dvd_l / dvs_l && rem_o == dvd_l % dvs_l));

  a_r4_zero_divisor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !sgn_l && dvs_l == '0) |-> (quot_o == '1 && rem_o == dvd_l));
endmodule

bind seq_divider div_checker #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_seq_divider.sv
`timescale 1ns/1ps
module sim_seq_divider;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, sgn = 1'b0;
  logic [W-1:0] dvd = '0, dvs = '0;
  logic busy, done;
  logic [W-1:0] quot, rem;

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  seq_divider #(.WIDTH(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .signed_i(sgn),
    .dividend_i(dvd), .divisor_i(dvs),
    .busy_o(busy), .done_o(done), .quot_o(quot), .rem_o(rem)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void ref_div(input logic [W-1:0] a, input logic [W-1:0] b, input logic s,
                                  output logic [W-1:0] q, output logic [W-1:0] r);
    int am, bm, qm, rm;
    am = (s && a[W-1]) ? (1 << W) - int'(a) : int'(a);
    bm = (s && b[W-1]) ? (1 << W) - int'(b) : int'(b);
    if (bm == 0) begin
      qm = (1 << W) - 1;
      rm = am;
    end else begin
      qm = am / bm;
      rm = am % bm;
    end
    if (s && (a[W-1] ^ b[W-1])) qm = -qm;
    if (s && a[W-1]) rm = -rm;
    q = qm[W-1:0];
    r = rm[W-1:0];
  endfunction

  task automatic run(input logic [W-1:0] a, input logic [W-1:0] b, input logic s,
                     input bit inj, input string tag);
    logic [W-1:0] eq, er;
    int cyc;
    ref_div(a, b, s, eq, er);
    @(negedge clk);
    dvd = a; dvs = b; sgn = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 64) begin
      chk({tag, " R5 busy during op"}, 32'(busy), 32'd1);
      if (inj && cyc == 2) begin
        start = 1'b1; dvd = ~a; dvs = b + 1'b1; sgn = ~s; // R6 ignored start
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk({tag, s ? " R3 latency" : " R2 latency"}, 32'(cyc), s ? 32'(W + 2) : 32'(W + 1));
    chk({tag, " R5 busy low at done"}, 32'(busy), 32'd0);
    chk({tag, s ? " R3 quotient" : (b == 0 ? " R4 quotient" : " R1 quotient")}, 32'(quot), 32'(eq));
    chk({tag, s ? " R3 remainder" : (b == 0 ? " R4 remainder" : " R1 remainder")}, 32'(rem), 32'(er));
    @(negedge clk);
    chk({tag, " R5 done one cycle"}, 32'(done), 32'd0);
    chk({tag, " R7 quotient held"}, 32'(quot), 32'(eq));
    chk({tag, " R7 remainder held"}, 32'(rem), 32'(er));
  endtask

  initial begin
    #1;
    // R8 reset state
    chk("R8 busy in reset", 32'(busy), 32'd0);
    chk("R8 done in reset", 32'(done), 32'd0);
    chk("R8 quot in reset", 32'(quot), 32'd0);
    chk("R8 rem in reset", 32'(rem), 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 idle after reset", 32'(busy), 32'd0);

    run(8'd200, 8'd7,   1'b0, 0, "u 200/7");
    run(8'd255, 8'd1,   1'b0, 0, "u 255/1");
    run(8'd5,   8'd9,   1'b0, 0, "u 5/9");
    run(8'd0,   8'd3,   1'b0, 0, "u 0/3");
    run(8'd255, 8'd255, 1'b0, 0, "u 255/255");
    run(8'd254, 8'd128, 1'b0, 0, "u 254/128");
    run(8'd100, 8'd0,   1'b0, 0, "u R4 100/0");
    run(8'h9c,  8'd7,   1'b1, 0, "s -100/7");
    run(8'd100, 8'hf9,  1'b1, 0, "s 100/-7");
    run(8'h9c,  8'hf9,  1'b1, 0, "s -100/-7");
    run(8'h80,  8'hff,  1'b1, 0, "s -128/-1");
    run(8'h80,  8'd1,   1'b1, 0, "s -128/1");
    run(8'hfb,  8'd0,   1'b1, 0, "s R4 -5/0");
    run(8'd123, 8'd10,  1'b0, 1, "u R6 inject");
    run(8'h85,  8'd3,   1'b1, 1, "s R6 inject");

    for (int i = 0; i < 80; i++) begin
      run(W'($urandom), W'($urandom_range(0, 255)), 1'($urandom), 0, "rand");
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule